// File: doc/BRIEF.md
# A/D Conversion Result Queue with Interrupt Requests

This block sits between an analogue-to-digital converter and a host. Each finished conversion is pushed into a first-in first-out queue, and the host pops results one at a time from the head. A data-ready flag is high whenever the queue holds at least one result. Two interrupt requests leave the block, and each has its own enable bit.

The first interrupt request is a level. It stays high while results wait in the queue and drops only when the host has read the queue empty. The second reports errors. An overflow occurs when a result arrives while the queue is full, and that result is dropped. An overrun occurs when a new convert strobe arrives while the previous conversion is still in progress. Each error is held in its own sticky latch. The host sees both latches as status bits and clears them with a single clear strobe.

A small state machine follows the converter. It has two states, CV_IDLE and CV_BUSY. The transition CV_IDLE→CV_BUSY happens on a convert strobe. CV_BUSY→CV_IDLE happens on a result strobe with no new convert strobe. CV_BUSY→CV_BUSY happens on a strobe pair, or on a lone convert strobe, which is the overrun case. Each error latch is a two-state machine with states ERR_CLEAR and ERR_HELD. ERR_CLEAR→ERR_HELD happens on an error event. ERR_HELD→ERR_CLEAR happens on a clear strobe with no new event in the same cycle.

Top module: `adc_result_fifo`

## Requirements
- R1: A result strobe `conv_done` writes `conv_data` into the queue at the clock edge. `rd_data` always shows the oldest stored result, and a `rd_en` pulse at an edge removes it. Results come out in arrival order.
- R2: `davail` is 1 exactly when the queue holds at least one result.
- R3: `irq_data` equals `fifo_irq_en AND davail`. It stays high across reads until the last result has been read.
- R4: A `conv_done` while the queue is full and `rd_en` is low discards the result and sets `ovf_flag` after that edge. If `rd_en` is high in the same cycle, the head is popped, the new result is stored, and no overflow is recorded.
- R5: A `conv_start` while `conv_busy` is 1 and `conv_done` is low sets `ovr_flag` after that edge. A `conv_start` together with `conv_done` is a legal back-to-back conversion and sets nothing.
- R6: `irq_err` equals `err_irq_en AND (ovf_flag OR ovr_flag)`.
- R7: Both error flags stay set until an `err_clr` pulse clears them. If a new error event of a kind arrives in the same cycle as `err_clr`, that flag stays set.
- R8: `rd_en` while the queue is empty has no effect. The queue stays empty and a result written afterwards is read normally.
- R9: After reset the queue is empty, all flags and both interrupts are 0, and `conv_busy` is 0.
- R10: `conv_busy` rises after an edge with `conv_start`. It falls after an edge with `conv_done` and no `conv_start`. It stays 1 when both strobes coincide.
- R11: `fifo_full` is 1 exactly when the queue holds DEPTH results. DEPTH defaults to 512 entries of 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Convert strobe to the converter |
| conv_done | input | 1 | Conversion-result strobe |
| conv_data | input | DATA_W | Conversion result |
| rd_en | input | 1 | Host pop of the queue head |
| rd_data | output | DATA_W | Oldest stored result |
| fifo_irq_en | input | 1 | Enable for the data interrupt |
| err_irq_en | input | 1 | Enable for the error interrupt |
| err_clr | input | 1 | Clear strobe for both error latches |
| davail | output | 1 | Data-ready status |
| fifo_full | output | 1 | Queue full status |
| ovf_flag | output | 1 | Overflow latch |
| ovr_flag | output | 1 | Overrun latch |
| conv_busy | output | 1 | Conversion in progress |
| irq_data | output | 1 | Data interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The assertions check every cycle that each error condition sets its latch at the next edge, that the latches are sticky and obey the clear strobe, that a read of an empty queue leaves it empty, and that both interrupt lines agree with their sources. Only the bench scenarios can show data ordering through a full 512-entry fill and drain, the dropped value on overflow, the head that replaces a popped slot when a read and a write hit a full queue, and the sequence of busy states across back-to-back conversions.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
    typedef enum logic [0:0] {
        CV_IDLE = 1'b0,
        CV_BUSY = 1'b1
    } cv_state_t;

    typedef enum logic [0:0] {
        ERR_CLEAR = 1'b0,
        ERR_HELD  = 1'b1
    } err_state_t;

    localparam int unsigned ERR_OVF = 0;
    localparam int unsigned ERR_OVR = 1;
    localparam int unsigned ERR_N   = 2;
endpackage

// File: rtl/adcq_fifo.sv
module adcq_fifo #(
    parameter int unsigned DW    = 16,
    parameter int unsigned DEPTH = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          full,
    output logic          ovf_evt
);
    localparam int unsigned AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          push_ok;
    logic          pop_ok;

    always_comb begin
        empty   = (count == '0);
        full    = (count == FULL_CNT);
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
        ovf_evt = push && full && !pop;
        rdata   = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/adcq_conv_fsm.sv
module adcq_conv_fsm
    import adcq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic conv_start,
    input  logic conv_done,
    output logic busy,
    output logic ovr_evt
);
    cv_state_t state_q;
    cv_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CV_IDLE: if (conv_start) state_d = CV_BUSY;
            CV_BUSY: if (conv_done && !conv_start) state_d = CV_IDLE;
            default: state_d = CV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        busy    = 1'b0;
        ovr_evt = 1'b0;
        unique case (state_q)
            CV_IDLE: busy = 1'b0;
            CV_BUSY: begin
                busy    = 1'b1;
                ovr_evt = conv_start && !conv_done;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/adcq_err_latch.sv
module adcq_err_latch
    import adcq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    output logic flag
);
    err_state_t state_q;
    err_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ERR_CLEAR: if (set_evt) state_d = ERR_HELD;
            ERR_HELD:  if (clr && !set_evt) state_d = ERR_CLEAR;
            default:   state_d = ERR_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ERR_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ERR_HELD: flag = 1'b1;
            default:  flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo
    import adcq_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              fifo_irq_en,
    input  logic              err_irq_en,
    input  logic              err_clr,
    output logic              davail,
    output logic              fifo_full,
    output logic              ovf_flag,
    output logic              ovr_flag,
    output logic              conv_busy,
    output logic              irq_data,
    output logic              irq_err
);
    logic             q_empty;
    logic [ERR_N-1:0] err_evt;
    logic [ERR_N-1:0] err_flag;

    adcq_fifo #(
        .DW    (DATA_W),
        .DEPTH (DEPTH)
    ) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (conv_done),
        .wdata   (conv_data),
        .pop     (rd_en),
        .rdata   (rd_data),
        .empty   (q_empty),
        .full    (fifo_full),
        .ovf_evt (err_evt[ERR_OVF])
    );

    adcq_conv_fsm conv_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .conv_done  (conv_done),
        .busy       (conv_busy),
        .ovr_evt    (err_evt[ERR_OVR])
    );

    for (genvar g = 0; g < ERR_N; g++) begin : g_err
        adcq_err_latch latch_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (err_evt[g]),
            .clr     (err_clr),
            .flag    (err_flag[g])
        );
    end

    always_comb begin
        davail   = !q_empty;
        ovf_flag = err_flag[ERR_OVF];
        ovr_flag = err_flag[ERR_OVR];
        irq_data = fifo_irq_en && davail;
        irq_err  = err_irq_en && (|err_flag);
    end
endmodule

// File: rtl/adcq_chk.sv
module adcq_chk (
    input logic clk,
    input logic rst_n,
    input logic conv_start,
    input logic conv_done,
    input logic rd_en,
    input logic err_clr,
    input logic fifo_irq_en,
    input logic err_irq_en,
    input logic davail,
    input logic fifo_full,
    input logic ovf_flag,
    input logic ovr_flag,
    input logic conv_busy,
    input logic irq_data,
    input logic irq_err
);
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full && conv_done && !rd_en |=> ovf_flag); // R4
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy && conv_start && !conv_done |=> ovr_flag); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !err_clr |=> ovf_flag); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag && !err_clr |=> ovr_flag); // R7
    AST_OVF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr && !(fifo_full && conv_done && !rd_en) |=> !ovf_flag); // R7
    AST_OVR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr && !(conv_busy && conv_start && !conv_done) |=> !ovr_flag); // R7
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !davail && rd_en && !conv_done |=> !davail); // R8
    AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> davail); // R11
    AST_IRQ_DATA_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_data |-> davail && fifo_irq_en); // R3
    AST_IRQ_ERR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> err_irq_en && (ovf_flag || ovr_flag)); // R6
    AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> conv_busy); // R10
    AST_PUSH_DAVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done && !rd_en |=> davail); // R2
endmodule

bind adc_result_fifo adcq_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_start  (conv_start),
    .conv_done   (conv_done),
    .rd_en       (rd_en),
    .err_clr     (err_clr),
    .fifo_irq_en (fifo_irq_en),
    .err_irq_en  (err_irq_en),
    .davail      (davail),
    .fifo_full   (fifo_full),
    .ovf_flag    (ovf_flag),
    .ovr_flag    (ovr_flag),
    .conv_busy   (conv_busy),
    .irq_data    (irq_data),
    .irq_err     (irq_err)
);

// File: tb/adc_result_fifo_tb.sv
module adc_result_fifo_tb_top;
    localparam int unsigned DW    = 16;
    localparam int unsigned DEPTH = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_start = 1'b0;
    logic          conv_done = 1'b0;
    logic [DW-1:0] conv_data = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          fifo_irq_en = 1'b0;
    logic          err_irq_en = 1'b0;
    logic          err_clr = 1'b0;
    logic          davail, fifo_full, ovf_flag, ovr_flag, conv_busy, irq_data, irq_err;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    adc_result_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
        .conv_data(conv_data), .rd_en(rd_en), .rd_data(rd_data),
        .fifo_irq_en(fifo_irq_en), .err_irq_en(err_irq_en), .err_clr(err_clr),
        .davail(davail), .fifo_full(fifo_full), .ovf_flag(ovf_flag),
        .ovr_flag(ovr_flag), .conv_busy(conv_busy), .irq_data(irq_data),
        .irq_err(irq_err)
    );

    typedef struct packed {
        logic          st;
        logic          dn;
        logic          rd;
        logic          clr;
        logic [15:0]   d;
        logic          e_busy;
        logic          e_dav;
        logic          e_ovr;
        logic [15:0]   e_head;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000},
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'h1111, 1'b0, 1'b1, 1'b0, 16'h1111},
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h1111},
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 16'h1111},
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'h2222, 1'b0, 1'b1, 1'b1, 16'h1111},
        '{1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h2222},
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h2222},
        '{1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{1'b1, 1'b1, 1'b0, 1'b0, 16'h3333, 1'b1, 1'b1, 1'b0, 16'h3333},
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'h4444, 1'b0, 1'b1, 1'b0, 16'h3333},
        '{1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h4444},
        '{1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000},
        '{1'b1, 1'b1, 1'b0, 1'b0, 16'h5555, 1'b1, 1'b1, 1'b0, 16'h5555},
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'h6666, 1'b0, 1'b1, 1'b0, 16'h5555},
        '{1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h6666},
        '{1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, pass one rising edge, return at the next falling edge.
    task automatic cyc(input logic st, input logic dn, input logic rd,
                       input logic clr, input logic [DW-1:0] d);
        conv_start = st; conv_done = dn; rd_en = rd; err_clr = clr; conv_data = d;
        @(posedge clk);
        @(negedge clk);
        conv_start = 1'b0; conv_done = 1'b0; rd_en = 1'b0; err_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 davail", davail, 0);
        check("R9 flags", {fifo_full, ovf_flag, ovr_flag, conv_busy}, 0);
        check("R9 irqs", {irq_data, irq_err}, 0);
        rst_n = 1'b1;
        fifo_irq_en = 1'b1;
        err_irq_en = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R3 R5 R6 R7 R8 R10
        for (int i = 0; i < NV; i++) begin
            cyc(VECS[i].st, VECS[i].dn, VECS[i].rd, VECS[i].clr, VECS[i].d);
            check("R10 busy", conv_busy, VECS[i].e_busy);
            check("R2 davail", davail, VECS[i].e_dav);
            check("R3 irq_data", irq_data, VECS[i].e_dav);
            check("R5 ovr_flag", ovr_flag, VECS[i].e_ovr);
            check("R6 irq_err", irq_err, VECS[i].e_ovr);
            if (VECS[i].e_dav) check("R1 head", rd_data, VECS[i].e_head);
        end

        // R3: enable gating of the data interrupt
        fifo_irq_en = 1'b0;
        cyc(0, 1, 0, 0, 16'hABCD);
        check("R3 gated", irq_data, 0);
        fifo_irq_en = 1'b1;
        #1 check("R3 enabled", irq_data, 1);
        cyc(0, 0, 1, 0, 0);
        check("R3 drained", irq_data, 0);

        // R11/R1: fill to DEPTH
        for (int i = 0; i < DEPTH; i++) begin
            cyc(0, 1, 0, 0, DW'(16'h1000 + i));
            if (i == DEPTH - 2) check("R11 not full", fifo_full, 0);
        end
        check("R11 full", fifo_full, 1);
        check("R4 no ovf yet", ovf_flag, 0);

        // R4: write while full is dropped
        err_irq_en = 1'b0;
        cyc(0, 1, 0, 0, 16'hDEAD);
        check("R4 ovf set", ovf_flag, 1);
        check("R6 err gated", irq_err, 0);
        err_irq_en = 1'b1;
        #1 check("R6 err enabled", irq_err, 1);

        // R7: set wins over clear
        cyc(0, 1, 0, 1, 16'hBEEF);
        check("R7 set wins", ovf_flag, 1);
        cyc(0, 0, 0, 1, 0);
        check("R7 clear", ovf_flag, 0);
        check("R6 err low", irq_err, 0);

        // R4: read plus write while full
        cyc(0, 1, 1, 0, 16'h7777);
        check("R4 no ovf with read", ovf_flag, 0);
        check("R4 still full", fifo_full, 1);
        check("R4 new head", rd_data, 16'h1001);

        // R1: drain in order
        for (int i = 1; i < DEPTH; i++) begin
            check("R1 order", rd_data, 32'(16'h1000 + i));
            cyc(0, 0, 1, 0, 0);
        end
        check("R1 last", rd_data, 16'h7777);
        check("R3 held before last", irq_data, 1);
        cyc(0, 0, 1, 0, 0);
        check("R2 empty", davail, 0);
        check("R3 cleared", irq_data, 0);

        // R8: read on empty is ignored
        cyc(0, 0, 1, 0, 0);
        cyc(0, 1, 0, 0, 16'h0F0F);
        check("R8 head after empty read", rd_data, 16'h0F0F);
        cyc(0, 0, 1, 0, 0);
        check("R8 empty again", davail, 0);

        done_flag = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule